// File: doc/BRIEF.md
# Lockable Signed Calibration Offset Register

This block is an 8-bit control register written and read by the host. Bits 6:0 hold a calibration offset in two's complement. Bit 7 is a lock flag that can only be set. The offset is sign-extended to 9 bits and added, modulo 512, to a temperature counter value that arrives on an input port. The sum is the word that feeds a thermal sensor DAC.

Setting the lock freezes the offset field. It also drops a write-allow output, which gates writes to a group of companion protection registers elsewhere on the chip. Two resets serve two domains. The platform reset is the only way to clear the lock. The power-good reset clears the offset field.

The lock is a two-state machine with the states UNLOCKED and LOCKED. The transition SET_LOCK goes from UNLOCKED to LOCKED on any write with bit 7 high. The state HOLD keeps LOCKED for every other input. Only an assertion of the platform reset returns the machine to UNLOCKED, through the transition PLAT_CLEAR. The offset field is a separate register. It has its own reset and is gated by the lock state held before the current clock edge.

Top module: `cal_offset_reg`

## Requirements
- R1: While `plat_rst_n` is low, the lock reads 0 and the offset field keeps its value.
- R2: While `pwr_rst_n` is low, the offset field reads 0 and the lock keeps its value.
- R3: A write with `wr_data[7]`=1 sets the lock on the next clock edge. A write with `wr_data[7]`=0 leaves the lock unchanged. No write clears the lock.
- R4: While unlocked, a write loads `wr_data[6:0]` into the offset field on the next clock edge.
- R5: While locked, writes leave the offset field unchanged.
- R6: When a write sets bit 7 and carries an offset in the same cycle, the offset is loaded if the lock was clear before that edge, and the lock is then set.
- R7: `rd_data` returns the lock in bit 7 and the offset in bits 6:0.
- R8: `prot_wr_allow` is 1 exactly while the lock is clear.
- R9: `dac_word` equals `count_in` plus the sign-extended offset, modulo 512, with no saturation.
- R10: Offset codes 00h–3Fh add +0 to +63. Codes 40h–7Fh add the code minus 128, so 40h adds −64 and 7Fh adds −1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| plat_rst_n | input | 1 | Platform reset, active low, clears the lock |
| pwr_rst_n | input | 1 | Power-good reset, active low, clears the offset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data: bit 7 lock request, bits 6:0 offset |
| rd_data | output | 8 | Read data: lock in bit 7, offset in bits 6:0 |
| count_in | input | 9 | Temperature counter value |
| dac_word | output | 9 | Counter plus sign-extended offset, modulo 512 |
| prot_wr_allow | output | 1 | Write permission for the companion protection registers |

## Verification
The bench writes the value 85h, which sets the lock and carries a new offset in the same write. A design that gates the offset with the new lock state would keep the old offset here. After the lock is set, the bench tries offset-only writes and zero writes. A design that lets either one through would either change the offset or reopen the companion registers. Each reset is pulsed alone. A design that shares one reset between the two domains would clear the field it must keep. The sum is swept over every offset code and checked at counter values that wrap. This sweep catches a zero-extended sign, 40h decoded as anything other than −64, and a saturating adder.

// File: rtl/cal_pkg.sv
package cal_pkg;
    localparam int REG_W  = 8;
    localparam int OFS_W  = REG_W - 1;
    localparam int SUM_W  = 9;

    typedef enum logic [0:0] {
        ST_UNLOCKED = 1'b0,
        ST_LOCKED   = 1'b1
    } lock_state_t;
endpackage

// File: rtl/cal_lock_fsm.sv
module cal_lock_fsm
    import cal_pkg::*;
(
    input  logic clk,
    input  logic plat_rst_n,
    input  logic wr_en,
    input  logic lock_req,
    output logic locked
);
    lock_state_t state_q;
    lock_state_t state_d;

    // Transitions: SET_LOCK (UNLOCKED->LOCKED on a write with the lock bit), HOLD otherwise.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_UNLOCKED: if (wr_en && lock_req) state_d = ST_LOCKED;
            ST_LOCKED:   state_d = ST_LOCKED;
            default:     state_d = ST_UNLOCKED;
        endcase
    end

    // State register. PLAT_CLEAR is the asynchronous reset to UNLOCKED.
    always_ff @(posedge clk or negedge plat_rst_n) begin
        if (!plat_rst_n) state_q <= ST_UNLOCKED;
        else             state_q <= state_d;
    end

    always_comb begin
        locked = (state_q == ST_LOCKED);
    end

    assert_lock_sticky_R3: assert property (@(posedge clk) disable iff (!plat_rst_n)
        locked |=> locked);

    assert_lock_cause_R3: assert property (@(posedge clk) disable iff (!plat_rst_n)
        $rose(locked) |-> $past(wr_en && lock_req));
endmodule

// File: rtl/cal_offset_field.sv
module cal_offset_field
    import cal_pkg::*;
#(
    parameter int W = OFS_W
) (
    input  logic         clk,
    input  logic         pwr_rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_ofs,
    input  logic         locked,
    output logic [W-1:0] ofs
);
    logic         load;
    logic [W-1:0] ofs_q;

    always_comb begin
        load = wr_en && !locked;
    end

    always_ff @(posedge clk or negedge pwr_rst_n) begin
        if (!pwr_rst_n)  ofs_q <= '0;
        else if (load)   ofs_q <= wr_ofs;
    end

    always_comb begin
        ofs = ofs_q;
    end

    assert_locked_frozen_R5: assert property (@(posedge clk) disable iff (!pwr_rst_n)
        locked |=> $stable(ofs));

    assert_open_load_R4: assert property (@(posedge clk) disable iff (!pwr_rst_n)
        (wr_en && !locked) |=> (ofs == $past(wr_ofs)));
endmodule

// File: rtl/cal_sum.sv
module cal_sum
    import cal_pkg::*;
#(
    parameter int OW = OFS_W,
    parameter int SW = SUM_W
) (
    input  logic          clk,
    input  logic          pwr_rst_n,
    input  logic [OW-1:0] ofs,
    input  logic [SW-1:0] cnt,
    output logic [SW-1:0] sum
);
    localparam int EXT      = SW - OW;
    localparam int POS_LIM  = 2 ** (OW - 1);
    localparam int NEG_BASE = 2 ** SW - POS_LIM;

    logic [SW-1:0] ofs_ext;

    generate
        if (EXT > 0) begin : g_extend
            always_comb ofs_ext = {{EXT{ofs[OW-1]}}, ofs};
        end else begin : g_direct
            always_comb ofs_ext = ofs[SW-1:0];
        end
    endgenerate

    always_comb begin
        sum = cnt + ofs_ext;
    end

    logic [SW-1:0] diff_chk;
    always_comb diff_chk = sum - cnt;

    assert_pos_range_R10: assert property (@(posedge clk) disable iff (!pwr_rst_n)
        !ofs[OW-1] |-> (int'(diff_chk) < POS_LIM));

    assert_neg_range_R10: assert property (@(posedge clk) disable iff (!pwr_rst_n)
        ofs[OW-1] |-> (int'(diff_chk) >= NEG_BASE));
endmodule

// File: rtl/cal_offset_reg.sv
module cal_offset_reg
    import cal_pkg::*;
(
    input  logic             clk,
    input  logic             plat_rst_n,
    input  logic             pwr_rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic [SUM_W-1:0] count_in,
    output logic [SUM_W-1:0] dac_word,
    output logic             prot_wr_allow
);
    logic             locked;
    logic [OFS_W-1:0] ofs;

    cal_lock_fsm u_lock (
        .clk        (clk),
        .plat_rst_n (plat_rst_n),
        .wr_en      (wr_en),
        .lock_req   (wr_data[REG_W-1]),
        .locked     (locked)
    );

    cal_offset_field #(.W(OFS_W)) u_field (
        .clk       (clk),
        .pwr_rst_n (pwr_rst_n),
        .wr_en     (wr_en),
        .wr_ofs    (wr_data[OFS_W-1:0]),
        .locked    (locked),
        .ofs       (ofs)
    );

    cal_sum #(.OW(OFS_W), .SW(SUM_W)) u_sum (
        .clk       (clk),
        .pwr_rst_n (pwr_rst_n),
        .ofs       (ofs),
        .cnt       (count_in),
        .sum       (dac_word)
    );

    always_comb begin
        rd_data       = {locked, ofs};
        prot_wr_allow = !locked;
    end

    assert_allow_tracks_lock_R8: assert property (@(posedge clk) disable iff (!plat_rst_n)
        $fell(prot_wr_allow) |-> $past(wr_en && wr_data[REG_W-1]));
endmodule

// File: tb/test_cal_offset_reg.sv
module test_cal_offset_reg;
    logic       clk = 1'b0;
    logic       plat_rst_n = 1'b0;
    logic       pwr_rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic [8:0] count_in = 9'h000;
    logic [8:0] dac_word;
    logic       prot_wr_allow;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cal_offset_reg i_cal_offset_reg (
        .clk(clk), .plat_rst_n(plat_rst_n), .pwr_rst_n(pwr_rst_n),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .count_in(count_in), .dac_word(dac_word), .prot_wr_allow(prot_wr_allow)
    );

    // Rows: {offset code, counter, expected sum}
    localparam int NV = 10;
    localparam logic [24:0] VEC [NV] = '{
        {7'h00, 9'h000, 9'h000},
        {7'h3F, 9'h000, 9'h03F},
        {7'h41, 9'h000, 9'h1C1},
        {7'h7F, 9'h005, 9'h004},
        {7'h40, 9'h100, 9'h0C0},
        {7'h40, 9'h000, 9'h1C0},
        {7'h3F, 9'h1FF, 9'h03E},
        {7'h01, 9'h1FF, 9'h000},
        {7'h7F, 9'h000, 9'h1FF},
        {7'h20, 9'h0A0, 9'h0C0}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = 8'h00;
    endtask

    function automatic int model_sum(input int code, input int cnt);
        int add;
        add = (code < 64) ? code : code + 384;
        return (cnt + add) % 512;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        plat_rst_n = 1'b1;
        pwr_rst_n = 1'b1;
        @(negedge clk);
        check("R7 reset read", rd_data, 8'h00);
        check("R8 reset allow", prot_wr_allow, 1);
        count_in = 9'h0AB;
        #1 check("R9 zero offset", dac_word, 9'h0AB);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            reg_write({1'b0, VEC[i][24:18]});
            count_in = VEC[i][17:9];
            #1 check("R9 vector", dac_word, VEC[i][8:0]);
            check("R4 vector load", rd_data, {1'b0, VEC[i][24:18]});
        end

        // Full sweep of offsets at several counter values
        for (int c = 0; c < 128; c++) begin
            reg_write(8'(c));
            for (int k = 0; k < 4; k++) begin
                int cv;
                cv = (k == 0) ? 0 : (k == 1) ? 63 : (k == 2) ? 448 : 511;
                count_in = 9'(cv);
                #1 check("R10 sweep", dac_word, model_sum(c, cv));
            end
        end

        // Bit 7 clear leaves lock open
        reg_write(8'h11);
        check("R3 zero bit7 no lock", prot_wr_allow, 1);

        // Same-cycle lock and offset
        reg_write(8'h85);
        check("R6 same cycle", rd_data, 8'h85);
        check("R8 locked allow", prot_wr_allow, 0);

        // Writes ignored while locked
        reg_write(8'h12);
        check("R5 locked write", rd_data, 8'h85);
        reg_write(8'h00);
        check("R3 zero write keeps lock", rd_data, 8'h85);
        count_in = 9'h010;
        #1 check("R9 locked sum", dac_word, 9'h015);

        // Power-good reset alone
        @(negedge clk) pwr_rst_n = 1'b0;
        @(negedge clk) pwr_rst_n = 1'b1;
        check("R2 pwr reset", rd_data, 8'h80);

        // Platform reset alone
        reg_write(8'h33);
        check("R5 locked after pwr", rd_data, 8'h80);
        @(negedge clk) plat_rst_n = 1'b0;
        @(negedge clk) plat_rst_n = 1'b1;
        check("R1 plat reset", rd_data, 8'h00);
        reg_write(8'h33);
        reg_write(8'hB3);
        check("R6 relock", rd_data, 8'hB3);
        @(negedge clk) plat_rst_n = 1'b0;
        @(negedge clk) plat_rst_n = 1'b1;
        check("R1 plat keeps offset", rd_data, 8'h33);
        check("R8 unlock allow", prot_wr_allow, 1);
        reg_write(8'h40);
        count_in = 9'h000;
        #1 check("R10 code 40h", dac_word, 9'h1C0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule